// File: doc/BRIEF.md
# Two-Wire Slave with Small Self-Timed Memory

This block is a slave on a two-wire serial bus (I2C-compatible framing) that fronts a sixteen-entry byte memory. The clock and data lines arrive already synchronised to the system clock. The data line is driven as an open-drain pull-down enable: when `sda_pull` is high, the pad pulls SDA low. The block watches the lines for START and STOP conditions. It shifts in a control byte, a word address and data bytes, and acknowledges each of them on the ninth clock. It keeps one address pointer that both writes and reads use.

A completed byte write is committed only when the STOP arrives. The commit opens a programming window of `WRITE_CLKS` system clocks. During that window the slave answers nothing on the bus, so a master can poll with write headers until it gets an acknowledge. Reads stream bytes MSB first from the pointer and advance it after every byte. The master keeps a read going by acknowledging each byte and ends it with a not-acknowledge followed by STOP.

The bus does not support back-pressure beyond the acknowledge itself. The slave never stretches SCL. The only flow control is the acknowledge it withholds during a programming window or for a foreign device code.

Top module: `i2c_small_mem_slave`

## Requirements
- R1: After reset `sda_pull` is low, the pointer is 0, every memory word reads 0x00 and no programming window is open.
- R2: A START (SDA falling while SCL is high) at any point, including mid-byte, discards the partial byte and restarts reception at the control byte. A STOP (SDA rising while SCL is high) returns the slave to idle.
- R3: A control byte whose bits [7:4] equal 1010 is acknowledged by raising `sda_pull` for the whole ninth clock. Bits [3:1] are ignored, and bit [0] selects read (1) or write (0). Any other code is not acknowledged, and the slave stays silent until the next START.
- R4: `sda_pull` only changes while SCL is low, except that a START or STOP releases it.
- R5: The byte after a write control byte is a word address. It is acknowledged, its bits [3:0] load the pointer, and its bits [7:4] are ignored.
- R6: Write control byte, word address, one data byte and STOP writes that byte to the pointer location. The pointer then still points at that location, and the memory changes only after a STOP.
- R7: A STOP before a data byte has been acknowledged, or a STOP after two or more bits of a further data byte, writes nothing and opens no programming window.
- R8: When several data bytes are acknowledged before STOP, each one replaces the previous one, and only the last is written.
- R9: A commit opens a window of exactly `WRITE_CLKS` clocks. During the window no byte is acknowledged and `sda_pull` stays low. After the window, acknowledges resume.
- R10: A read control byte returns the byte at the pointer, MSB first, with the slave pulling SDA low for each 0 bit. The pointer advances by one after every byte sent and wraps from 15 to 0.
- R11: A write header with a word address, followed by a repeated START and a read control byte, returns the byte at that address.
- R12: A master acknowledge after a read byte makes the slave send the next byte. A master not-acknowledge makes it release SDA and wait for START or STOP, with the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line (wired-AND of all drivers) |
| sda_pull | output | 1 | Pull-down enable for the open-drain SDA pad |

## Verification
The bench checks three write paths against a STOP that arrives at the wrong moment. A STOP straight after the address must write nothing, a STOP three bits into a second data byte must abort the whole write, and two full data bytes must leave only the second one. A design that commits on any STOP, or that keeps the first byte, would show the wrong value in the read that follows. Polls sent straight after a commit must go unanswered, and polls sent after the window must be acknowledged, which catches a timer that is off or never expires. A sequential read starting at address 15 exposes a pointer that fails to wrap. A START in the middle of a control byte, and a foreign device code followed by more bytes, expose a bit counter or decoder that does not resynchronise.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_WADDR,
    PH_WDATA,
    PH_RDATA
  } phase_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int         BYTE_W   = 8;
endpackage

// File: rtl/i2cmem_line_events.sv
module i2cmem_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_ev = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_ev  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2cmem_store.sv
module i2cmem_store #(
  parameter int WORDS  = 16,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words[w] <= '0;
      else if (we && (waddr == AW'(w)))
        words[w] <= wdata;
    end
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/i2cmem_prog_timer.sv
module i2cmem_prog_timer #(
  parameter int CYCLES = 1000,
  localparam int CW    = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy
);
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      left <= '0;
    else if (launch)
      left <= CW'(CYCLES);
    else if (left != '0)
      left <= left - 1'b1;
  end

  assign busy = (left != '0);
endmodule

// File: rtl/i2cmem_protocol.sv
module i2cmem_protocol
  import i2cmem_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_i,
  input  logic              busy,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [AW-1:0]     ptr,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              sda_pull,
  output phase_e            phase_o,
  output logic [3:0]        bit_cnt_o
);
  phase_e            phase;
  phase_e            nxt;
  phase_e            ack_next;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sr;
  logic [BYTE_W-1:0] tx;
  logic [BYTE_W-1:0] wbuf;
  logic              have_data;
  logic              mack;
  logic              ack_ok;

  // acknowledge decision for the byte just shifted in
  always_comb begin
    ack_ok   = 1'b0;
    ack_next = PH_IDLE;
    case (phase)
      PH_CTRL: begin
        ack_ok   = !busy && (sr[7:4] == DEV_CODE);
        ack_next = sr[0] ? PH_RDATA : PH_WADDR;
      end
      PH_WADDR: begin
        ack_ok   = !busy;
        ack_next = PH_WDATA;
      end
      PH_WDATA: begin
        ack_ok   = !busy;
        ack_next = PH_WDATA;
      end
      default: begin
        ack_ok   = 1'b0;
        ack_next = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      nxt       <= PH_IDLE;
      cnt       <= '0;
      sr        <= '0;
      tx        <= '0;
      wbuf      <= '0;
      have_data <= 1'b0;
      mack      <= 1'b0;
      ptr       <= '0;
      mem_we    <= 1'b0;
      sda_pull  <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (start_ev) begin
        phase     <= PH_CTRL;
        cnt       <= '0;
        sda_pull  <= 1'b0;
        have_data <= 1'b0;
      end else if (stop_ev) begin
        // commit only when a full data byte was acknowledged and no
        // further data bit preceded the STOP clock
        if (phase == PH_WDATA && have_data && cnt <= 4'd1)
          mem_we <= 1'b1;
        phase     <= PH_IDLE;
        cnt       <= '0;
        sda_pull  <= 1'b0;
        have_data <= 1'b0;
      end else if (phase == PH_RDATA) begin
        if (scl_rise) begin
          if (cnt < 4'd8) begin
            cnt <= cnt + 4'd1;
          end else if (cnt == 4'd8) begin
            mack <= ~sda_i;
            cnt  <= 4'd9;
          end
        end else if (scl_fall) begin
          if (cnt >= 4'd1 && cnt <= 4'd7) begin
            sda_pull <= ~tx[3'(4'd7 - cnt)];
          end else if (cnt == 4'd8) begin
            sda_pull <= 1'b0;
            ptr      <= ptr + 1'b1;
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            if (mack) begin
              tx       <= rd_data;
              sda_pull <= ~rd_data[7];
            end else begin
              phase    <= PH_IDLE;
              sda_pull <= 1'b0;
            end
          end
        end
      end else if (phase != PH_IDLE) begin
        if (scl_rise && cnt < 4'd8) begin
          sr  <= {sr[6:0], sda_i};
          cnt <= cnt + 4'd1;
        end else if (scl_fall && cnt == 4'd8) begin
          cnt      <= 4'd9;
          sda_pull <= ack_ok;
          nxt      <= ack_ok ? ack_next : PH_IDLE;
          if (ack_ok && phase == PH_WADDR)
            ptr <= sr[AW-1:0];
          if (ack_ok && phase == PH_WDATA) begin
            wbuf      <= sr;
            have_data <= 1'b1;
          end
        end else if (scl_fall && cnt == 4'd9) begin
          cnt      <= '0;
          phase    <= nxt;
          sda_pull <= 1'b0;
          if (nxt == PH_RDATA) begin
            tx       <= rd_data;
            sda_pull <= ~rd_data[7];
          end
        end
      end
    end
  end

  assign mem_wdata = wbuf;
  assign phase_o   = phase;
  assign bit_cnt_o = cnt;
endmodule

// File: rtl/i2c_small_mem_slave.sv
module i2c_small_mem_slave
  import i2cmem_pkg::*;
#(
  parameter int WORDS      = 16,
  parameter int WRITE_CLKS = 200000,
  localparam int AW        = $clog2(WORDS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull
);
  logic              scl_rise;
  logic              scl_fall;
  logic              start_ev;
  logic              stop_ev;
  logic              busy;
  logic              mem_we;
  logic [AW-1:0]     ptr;
  logic [BYTE_W-1:0] mem_wdata;
  logic [BYTE_W-1:0] rd_data;
  phase_e            phase;
  logic [3:0]        bit_cnt;

  i2cmem_line_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2cmem_protocol #(.AW(AW)) u_proto (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .sda_i     (sda_i),
    .busy      (busy),
    .rd_data   (rd_data),
    .ptr       (ptr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .sda_pull  (sda_pull),
    .phase_o   (phase),
    .bit_cnt_o (bit_cnt)
  );

  i2cmem_store #(.WORDS(WORDS), .DATA_W(BYTE_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (ptr),
    .wdata (mem_wdata),
    .raddr (ptr),
    .rdata (rd_data)
  );

  i2cmem_prog_timer #(.CYCLES(WRITE_CLKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (mem_we),
    .busy   (busy)
  );
endmodule

// File: rtl/i2cmem_checker.sv
module i2cmem_checker
  import i2cmem_pkg::*;
#(
  parameter int WRITE_CLKS = 1000,
  localparam int CW        = (WRITE_CLKS < 2) ? 1 : $clog2(WRITE_CLKS + 1)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_pull,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       mem_we,
  input logic       busy,
  input phase_e     phase,
  input logic [3:0] bit_cnt
);
  logic [CW-1:0] win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      win <= '0;
    else if (mem_we)
      win <= CW'(WRITE_CLKS);
    else if (win != '0)
      win <= win - 1'b1;
  end

  assert_pull_rises_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_i);

  assert_pull_steady_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_pull));

  assert_silent_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull);

  assert_window_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (win != '0) == busy);

  assert_commit_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(stop_ev));

  assert_stop_to_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (phase == PH_IDLE));

  assert_start_rearms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (phase == PH_CTRL && bit_cnt == 4'd0));
endmodule

bind i2c_small_mem_slave i2cmem_checker #(.WRITE_CLKS(WRITE_CLKS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_pull (sda_pull),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .mem_we   (mem_we),
  .busy     (busy),
  .phase    (phase),
  .bit_cnt  (bit_cnt)
);

// File: tb/i2c_small_mem_slave_test.sv
module i2c_small_mem_slave_test;
  localparam int WCLK = 300;
  localparam int Q    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic msda = 1'b1;
  logic sda_pull;
  logic sda_line;

  assign sda_line = msda & ~sda_pull;

  always #10 clk = ~clk;

  i2c_small_mem_slave #(.WRITE_CLKS(WCLK)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .sda_pull (sda_pull)
  );

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    busy_until = -1;
  logic  exp_pull = 1'b0;
  bit    mon_on = 1'b0;
  string cur_req = "R1";
  logic [7:0] ref_mem [16];
  int    ref_ptr = 0;
  logic [7:0] pend_data = 8'h00;

  // per-clock comparison of the pull-down against the reference
  always @(posedge clk) begin
    cyc++;
    #2;
    if (mon_on) begin
      checks++;
      if (sda_pull !== exp_pull) begin
        errors++;
        $display("FAIL %s: sda_pull actual %b expected %b at cycle %0d",
                 cur_req, sda_pull, exp_pull, cyc);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: all requirements, actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  function automatic bit ctrl_acks(logic [7:0] b);
    return (b[7:4] == 4'b1010) && (cyc > busy_until);
  endfunction

  task automatic bstart();
    msda = 1'b1; hq();
    scl = 1'b1; hq();
    msda = 1'b0; exp_pull = 1'b0; hq();
    scl = 1'b0; hq();
  endtask

  task automatic bstop(bit commit);
    msda = 1'b0; hq();
    scl = 1'b1; hq();
    msda = 1'b1; exp_pull = 1'b0;
    if (commit) begin
      ref_mem[ref_ptr] = pend_data;
      busy_until = cyc + WCLK + 4;
    end
    hq();
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      msda = b[i]; hq();
      scl = 1'b1; hq();
      scl = 1'b0;
    end
  endtask

  task automatic send_byte(logic [7:0] b, bit ack_exp, logic after, string req);
    logic seen;
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; hq();
      scl = 1'b1; hq();
      scl = 1'b0;
    end
    msda = 1'b1;
    exp_pull = ack_exp;
    hq();
    scl = 1'b1;
    repeat (2) @(negedge clk);
    seen = ~sda_line;
    repeat (2) @(negedge clk);
    scl = 1'b0;
    exp_pull = after;
    chk(req, int'(seen), int'(ack_exp), "acknowledge");
  endtask

  task automatic recv_byte(bit mack, string req);
    logic [7:0] got;
    logic [7:0] exp;
    exp = ref_mem[ref_ptr];
    for (int i = 7; i >= 0; i--) begin
      hq();
      scl = 1'b1;
      repeat (2) @(negedge clk);
      got[i] = sda_line;
      repeat (2) @(negedge clk);
      scl = 1'b0;
      exp_pull = (i > 0) ? ~exp[i-1] : 1'b0;
    end
    ref_ptr = (ref_ptr + 1) % 16;
    msda = mack ? 1'b0 : 1'b1;
    hq();
    scl = 1'b1; hq();
    scl = 1'b0;
    exp_pull = mack ? ~ref_mem[ref_ptr][7] : 1'b0;
    msda = 1'b1;
    chk(req, int'(got), int'(exp), "read byte");
  endtask

  task automatic do_write(logic [7:0] addr, logic [7:0] data);
    bstart();
    send_byte(8'hA0, 1'b1, 1'b0, "R6");
    send_byte(addr, 1'b1, 1'b0, "R5");
    ref_ptr = int'(addr[3:0]);
    send_byte(data, 1'b1, 1'b0, "R6");
    pend_data = data;
    bstop(1'b1);
    repeat (WCLK + 20) @(negedge clk);
  endtask

  task automatic rd_from(logic [7:0] addr, int n, string req);
    bstart();
    send_byte(8'hA0, 1'b1, 1'b0, "R11");
    send_byte(addr, 1'b1, 1'b0, "R5");
    ref_ptr = int'(addr[3:0]);
    bstart();
    send_byte(8'hA1, 1'b1, ~ref_mem[ref_ptr][7], "R11");
    for (int k = 0; k < n; k++)
      recv_byte(k < n - 1, req);
    bstop(1'b0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) ref_mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    // R1: reset state, then a current-address read of word 0
    cur_req = "R1";
    chk("R1", int'(sda_pull), 0, "pull after reset");
    bstart();
    send_byte(8'hA1, 1'b1, ~ref_mem[0][7], "R1");
    recv_byte(1'b0, "R1");
    bstop(1'b0);

    // R3/R5/R6: byte write with don't-care bits set, upper address nibble set
    cur_req = "R6";
    bstart();
    send_byte(8'hAE, 1'b1, 1'b0, "R3");
    send_byte(8'hF3, 1'b1, 1'b0, "R5");
    ref_ptr = 3;
    send_byte(8'h5A, 1'b1, 1'b0, "R6");
    pend_data = 8'h5A;
    bstop(1'b1);

    // R9: poll during the window goes unanswered, a later one is answered
    cur_req = "R9";
    bstart();
    send_byte(8'hA0, ctrl_acks(8'hA0), 1'b0, "R9");
    chk("R9", int'(ctrl_acks(8'hA0)), 0, "window open");
    bstop(1'b0);
    bstart();
    send_byte(8'hA1, 1'b0, 1'b0, "R9");
    bstop(1'b0);
    repeat (WCLK + 20) @(negedge clk);
    bstart();
    send_byte(8'hA0, 1'b1, 1'b0, "R9");
    bstop(1'b0);

    // R6: pointer stays on the written word; current read with don't-cares
    cur_req = "R6";
    bstart();
    send_byte(8'hAB, 1'b1, ~ref_mem[ref_ptr][7], "R3");
    recv_byte(1'b0, "R6");
    bstop(1'b0);

    // R10/R11/R12: sequential read across the 15 -> 0 wrap
    cur_req = "R10";
    do_write(8'h0F, 8'h81);
    do_write(8'h00, 8'h3C);
    do_write(8'h01, 8'hC3);
    rd_from(8'h0F, 3, "R10");
    chk("R12", ref_ptr, 2, "pointer after three reads");

    // R7: STOP in the middle of the first data byte
    cur_req = "R7";
    bstart();
    send_byte(8'hA0, 1'b1, 1'b0, "R7");
    send_byte(8'h05, 1'b1, 1'b0, "R5");
    ref_ptr = 5;
    send_bits(8'hFF, 4);
    bstop(1'b0);
    bstart();
    send_byte(8'hA0, 1'b1, 1'b0, "R7");
    send_byte(8'h25, 1'b1, 1'b0, "R5");
    bstop(1'b0);
    rd_from(8'h05, 1, "R7");

    // R8: two data bytes, only the second lands
    cur_req = "R8";
    bstart();
    send_byte(8'hA0, 1'b1, 1'b0, "R8");
    send_byte(8'h06, 1'b1, 1'b0, "R5");
    ref_ptr = 6;
    send_byte(8'h11, 1'b1, 1'b0, "R8");
    send_byte(8'h22, 1'b1, 1'b0, "R8");
    pend_data = 8'h22;
    bstop(1'b1);
    repeat (WCLK + 20) @(negedge clk);

    // R7: full byte then three bits of another byte before STOP
    cur_req = "R7";
    bstart();
    send_byte(8'hA0, 1'b1, 1'b0, "R7");
    send_byte(8'h07, 1'b1, 1'b0, "R5");
    ref_ptr = 7;
    send_byte(8'h33, 1'b1, 1'b0, "R7");
    send_bits(8'h80, 3);
    bstop(1'b0);
    cur_req = "R8";
    rd_from(8'h06, 2, "R8");

    // R3: foreign device codes are not answered, nor anything after them
    cur_req = "R3";
    bstart();
    send_byte(8'h50, 1'b0, 1'b0, "R3");
    send_byte(8'hA0, 1'b0, 1'b0, "R3");
    bstop(1'b0);
    bstart();
    send_byte(8'hB1, 1'b0, 1'b0, "R3");
    bstop(1'b0);

    // R2: START in the middle of a control byte restarts reception
    cur_req = "R2";
    bstart();
    send_bits(8'hA0, 5);
    bstart();
    send_byte(8'hA1, 1'b1, ~ref_mem[ref_ptr][7], "R2");
    recv_byte(1'b0, "R2");
    bstop(1'b0);

    // R9: a read header during the window is also ignored
    cur_req = "R9";
    bstart();
    send_byte(8'hA0, 1'b1, 1'b0, "R9");
    send_byte(8'h09, 1'b1, 1'b0, "R5");
    ref_ptr = 9;
    send_byte(8'h96, 1'b1, 1'b0, "R9");
    pend_data = 8'h96;
    bstop(1'b1);
    bstart();
    send_byte(8'hA1, 1'b0, 1'b0, "R9");
    bstop(1'b0);
    repeat (WCLK + 20) @(negedge clk);
    cur_req = "R11";
    rd_from(8'h09, 1, "R11");

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule